// File: doc/BRIEF.md
# Global-Chop Conversion Sequencer

This block schedules offset-cancelling chopped conversions for a multi-channel delta-sigma ADC front end. It runs on the modulator clock, so one clock cycle is one modulator period. In chop mode it flips the input polarity on every internal conversion and drives that polarity to the analog switches. At each flip it pulses a reset to the decimation filter. It then waits a programmable settling delay and counts three filter output periods (3 × OSR clocks). At the end of that count it takes the filter output of every channel.

Each new internal sample is combined with the one before it, which was taken at the opposite polarity. The reversed-polarity sample is negated, the two are summed and the sum is halved. The result is registered per channel, and an active-low data-ready strobe falls. With chop mode off, the block passes one filter sample per OSR clocks straight through. A falling edge on the sync input, a new OSR value or a change of mode restarts all channels together. In chop mode the first result after a restart comes after a fixed start-up wait plus two full chopped conversions.

Top module: `gchop_sequencer`

## Requirements
- R1: On the first clock edge after reset is released the block restarts: data-ready is high (1), polarity is normal (0) and every result word is 0.
- R2: In chop mode the polarity output starts at 0 (normal) after a restart. It toggles to 1 (reversed) and back at the end of every internal conversion.
- R3: The filter-reset output is high for exactly one cycle after each restart edge and after each edge that toggles the polarity, and is low otherwise.
- R4: A delay code n (4 bits) gives a settling delay of 2^(n+1) clocks, so code 0 is 2 clocks and code 15 is 65,536 clocks. Each internal conversion lasts 3 × OSR clocks after the delay.
- R5: In chop mode, with D the delay and P = D + 3 × OSR, internal conversions end 44 + k × P clocks after the restart edge (k = 1, 2, ...). Results appear from k = 2 on, so the first comes at 44 + 2P and later ones every P clocks.
- R6: A chopped result for each channel is (A − B) >> 1 (arithmetic) over a 25-bit signed sum. A is the normal-polarity sample and B the reversed one of the two most recent samples. Samples are signed 24-bit, and channel c sits at bits [24c+23:24c] of the sample and result buses.
- R7: Data-ready falls on the edge that updates the results. It stays low for 8 clocks, or it rises on the edge after the host read input is seen high, whichever comes first. The result outputs change only on an edge that drives data-ready low.
- R8: A falling edge of the sync input, any change of the OSR input or any change of the chop-enable input restarts the sequence on that edge. A restart does not change the result outputs.
- R9: With chop mode off, polarity stays 0 and each result equals the filter sample taken OSR clocks after the restart and every OSR clocks after that.
- R10: While chop-enable is high, the phase-calibration and DC-test enable outputs are 0. Otherwise they follow their request inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chopEn | input | 1 | Chop mode enable |
| osr | input | 16 | Oversampling ratio, 1 or more |
| dlyCode | input | 4 | Settling delay code |
| syncN | input | 1 | Sync/restart input, falling edge restarts |
| hostRead | input | 1 | Host has read the result |
| phaseCalReq | input | 1 | Phase calibration request |
| dcTestReq | input | 1 | DC test-signal request |
| sampleData | input | 72 | Filter output, one signed 24-bit word per channel |
| chopPol | output | 1 | Input polarity to the chop switches, 1 = reversed |
| filterRst | output | 1 | Filter reset strobe |
| drdyN | output | 1 | Active-low data-ready |
| result | output | 72 | Chopped or passed-through result per channel |
| phaseCalEn | output | 1 | Phase calibration enable after gating |
| dcTestEn | output | 1 | DC test-signal enable after gating |

## Verification
The filter sample taken at edge N is the value driven in the cycle before N. A result therefore reaches the outputs in the cycle that follows the edge 44 + k × P (chop) or k × OSR (pass-through) clocks after the restart edge. The restart edge is the first edge that sees the sync, OSR or mode change. The bench counts edges from that restart edge and computes, for every cycle, the expected polarity, filter-reset, data-ready and result. It compares them half a cycle after each edge. This covers the 44 + 2P first-result latency, the P spacing, the 8-clock data-ready pulse and the one-edge data-ready release after a host read. The longest delay code is run to its first result.

// File: rtl/gchop_pkg.sv
package gchop_pkg;
  localparam int START_CLKS = 44;

  typedef enum logic [1:0] {ST_START, ST_DELAY, ST_CONV} gchop_state_t;

  typedef struct packed {
    logic capture;
    logic publish;
    logic invert;
    logic bypass;
  } gchop_strobe_t;
endpackage

// File: rtl/gchop_ctrl.sv
module gchop_ctrl
  import gchop_pkg::*;
#(
  parameter int OSR_W    = 16,
  parameter int RDY_HOLD = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chopEn,
  input  logic [OSR_W-1:0] osr,
  input  logic [3:0]       dlyCode,
  input  logic             syncN,
  input  logic             hostRead,
  output gchop_strobe_t    strobe,
  output logic             chopPol,
  output logic             filterRst,
  output logic             drdyN
);
  localparam int CNT_W  = (OSR_W + 2 > 17) ? OSR_W + 2 : 17;
  localparam int HOLD_W = (RDY_HOLD > 1) ? $clog2(RDY_HOLD) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(RDY_HOLD - 1);

  gchop_state_t      state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  dlyLoad, convLoad, osrLoad;
  logic [OSR_W-1:0]  osrPrev;
  logic [HOLD_W-1:0] holdCnt;
  logic pend, syncPrev, modePrev, chopMode, havePrev;
  logic restartEvt, convEnd;

  always_comb begin
    dlyLoad    = (CNT_W'(1) << (5'(dlyCode) + 5'd1)) - CNT_W'(1);
    convLoad   = CNT_W'(osr) + (CNT_W'(osr) << 1) - CNT_W'(1);
    osrLoad    = CNT_W'(osr) - CNT_W'(1);
    restartEvt = pend | (syncPrev & ~syncN) | (osr != osrPrev) | (chopEn != modePrev);
    convEnd    = (state == ST_CONV) && (cnt == '0) && !restartEvt;
    strobe.capture = convEnd;
    strobe.publish = convEnd && (!chopMode || havePrev);
    strobe.invert  = chopPol;
    strobe.bypass  = !chopMode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b1;
      syncPrev  <= 1'b1;
      osrPrev   <= '0;
      modePrev  <= 1'b0;
      state     <= ST_START;
      cnt       <= '0;
      chopMode  <= 1'b0;
      chopPol   <= 1'b0;
      havePrev  <= 1'b0;
      filterRst <= 1'b0;
    end else begin
      pend      <= 1'b0;
      syncPrev  <= syncN;
      osrPrev   <= osr;
      modePrev  <= chopEn;
      filterRst <= 1'b0;
      if (restartEvt) begin
        chopMode  <= chopEn;
        chopPol   <= 1'b0;
        havePrev  <= 1'b0;
        filterRst <= 1'b1;
        if (chopEn) begin
          state <= ST_START;
          cnt   <= CNT_W'(START_CLKS - 1);
        end else begin
          state <= ST_CONV;
          cnt   <= osrLoad;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end else begin
        unique case (state)
          ST_START: begin
            state <= ST_DELAY;
            cnt   <= dlyLoad;
          end
          ST_DELAY: begin
            state <= ST_CONV;
            cnt   <= convLoad;
          end
          default: begin
            if (chopMode) begin
              chopPol   <= ~chopPol;
              havePrev  <= 1'b1;
              filterRst <= 1'b1;
              state     <= ST_DELAY;
              cnt       <= dlyLoad;
            end else begin
              cnt <= osrLoad;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdyN   <= 1'b1;
      holdCnt <= '0;
    end else if (restartEvt) begin
      drdyN <= 1'b1;
    end else if (strobe.publish) begin
      drdyN   <= 1'b0;
      holdCnt <= HOLD_LOAD;
    end else if (!drdyN) begin
      if (hostRead || holdCnt == '0) drdyN <= 1'b1;
      else holdCnt <= holdCnt - HOLD_W'(1);
    end
  end
endmodule

// File: rtl/gchop_datapath.sv
module gchop_datapath
  import gchop_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int SAMPLE_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  gchop_strobe_t              strobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  output logic [NUM_CH*SAMPLE_W-1:0] result
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic signed [SAMPLE_W-1:0] curS, prevS, resS;
    logic signed [SAMPLE_W:0]   sumS;

    always_comb begin
      curS = sampleData[ch*SAMPLE_W +: SAMPLE_W];
      if (strobe.invert) sumS = {prevS[SAMPLE_W-1], prevS} - {curS[SAMPLE_W-1], curS};
      else               sumS = {curS[SAMPLE_W-1], curS} - {prevS[SAMPLE_W-1], prevS};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prevS <= '0;
        resS  <= '0;
      end else begin
        if (strobe.capture) prevS <= curS;
        if (strobe.publish) resS <= strobe.bypass ? curS : sumS[SAMPLE_W:1];
      end
    end

    assign result[ch*SAMPLE_W +: SAMPLE_W] = resS;
  end
endmodule

// File: rtl/gchop_sequencer.sv
module gchop_sequencer
  import gchop_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int SAMPLE_W = 24,
  parameter int OSR_W    = 16,
  parameter int RDY_HOLD = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       chopEn,
  input  logic [OSR_W-1:0]           osr,
  input  logic [3:0]                 dlyCode,
  input  logic                       syncN,
  input  logic                       hostRead,
  input  logic                       phaseCalReq,
  input  logic                       dcTestReq,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  output logic                       chopPol,
  output logic                       filterRst,
  output logic                       drdyN,
  output logic [NUM_CH*SAMPLE_W-1:0] result,
  output logic                       phaseCalEn,
  output logic                       dcTestEn
);
  gchop_strobe_t strobe;

  gchop_ctrl #(.OSR_W(OSR_W), .RDY_HOLD(RDY_HOLD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chopEn(chopEn), .osr(osr), .dlyCode(dlyCode),
    .syncN(syncN), .hostRead(hostRead), .strobe(strobe), .chopPol(chopPol),
    .filterRst(filterRst), .drdyN(drdyN)
  );

  gchop_datapath #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sampleData(sampleData), .result(result)
  );

  assign phaseCalEn = phaseCalReq & ~chopEn;
  assign dcTestEn   = dcTestReq & ~chopEn;
endmodule

// File: rtl/gchop_checker.sv
module gchop_checker #(
  parameter int NUM_CH   = 3,
  parameter int SAMPLE_W = 24
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       chopEn,
  input logic                       syncN,
  input logic                       chopPol,
  input logic                       filterRst,
  input logic                       drdyN,
  input logic [NUM_CH*SAMPLE_W-1:0] result,
  input logic                       phaseCalEn,
  input logic                       dcTestEn
);
  // R3
  pol_swap_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chopPol != $past(chopPol)) |-> filterRst);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> !drdyN);

  // R8
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(syncN) |=> (drdyN && !chopPol));

  // R9
  passthru_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chopEn |=> !chopPol);

  // R10
  cal_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chopEn |-> (!phaseCalEn && !dcTestEn));
endmodule

bind gchop_sequencer gchop_checker #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chopEn(chopEn), .syncN(syncN), .chopPol(chopPol),
  .filterRst(filterRst), .drdyN(drdyN), .result(result),
  .phaseCalEn(phaseCalEn), .dcTestEn(dcTestEn)
);

// File: tb/gchop_sequencer_test.sv
`timescale 1ns/1ps
module gchop_sequencer_test;
  localparam int NCH  = 2;
  localparam int SW   = 24;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chopEn = 1'b1;
  logic [15:0] osr = 16'd4;
  logic [3:0] dlyCode = 4'd0;
  logic syncN = 1'b1;
  logic hostRead = 1'b0;
  logic phaseCalReq = 1'b1;
  logic dcTestReq = 1'b1;
  logic [NCH*SW-1:0] sampleData = '0;
  logic chopPol, filterRst, drdyN, phaseCalEn, dcTestEn;
  logic [NCH*SW-1:0] result;

  gchop_sequencer #(.NUM_CH(NCH), .SAMPLE_W(SW), .OSR_W(16), .RDY_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .chopEn(chopEn), .osr(osr), .dlyCode(dlyCode),
    .syncN(syncN), .hostRead(hostRead), .phaseCalReq(phaseCalReq), .dcTestReq(dcTestReq),
    .sampleData(sampleData), .chopPol(chopPol), .filterRst(filterRst), .drdyN(drdyN),
    .result(result), .phaseCalEn(phaseCalEn), .dcTestEn(dcTestEn)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int unsigned edgeCnt = 0;
  always @(posedge clk) edgeCnt = edgeCnt + 1;

  // model state
  bit tracking = 0, pending = 0, nextChop = 0, runChop = 0, nextViaEvt = 0, viaEvt = 0;
  int unsigned nextE0, nextOsr, nextCode, E0, osrRun, P, k, lastPub, readAt;
  bit havePub = 0;
  string drdyTag = "R5";
  logic [SW-1:0] prevS [NCH];
  logic [NCH*SW-1:0] expRes = '0;

  function automatic logic [SW-1:0] smp(int unsigned t, int ch);
    logic [31:0] x;
    x = t * 32'h9E3779B1 + ch * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x[SW-1:0];
  endfunction

  function automatic logic [SW-1:0] chopAvg(logic [SW-1:0] prv, logic [SW-1:0] cr, bit crRev);
    logic signed [SW:0] d;
    if (crRev) d = $signed({prv[SW-1], prv}) - $signed({cr[SW-1], cr});
    else       d = $signed({cr[SW-1], cr}) - $signed({prv[SW-1], prv});
    return d[SW:1];
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h", tag, what, edgeCnt, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int unsigned t;
    bit isCap, pubNow, expPol, expFr, expDrdy;
    logic [SW-1:0] cur;
    t = edgeCnt;
    if (pending && t == nextE0) begin
      pending = 0; tracking = 1; E0 = nextE0; runChop = nextChop; osrRun = nextOsr;
      P = (1 << (nextCode + 1)) + 3 * nextOsr; k = 0; havePub = 0; readAt = 0; viaEvt = nextViaEvt;
    end
    if (tracking) begin
      isCap = 0; pubNow = 0;
      if (runChop) isCap = (t > E0 + 44) && (((t - E0 - 44) % P) == 0);
      else         isCap = (t > E0) && (((t - E0) % osrRun) == 0);
      if (isCap) begin
        k++;
        for (int ch = 0; ch < NCH; ch++) begin
          cur = smp(t - 1, ch);
          if (!runChop) expRes[ch*SW +: SW] = cur;
          else if (k >= 2) expRes[ch*SW +: SW] = chopAvg(prevS[ch], cur, ((k - 1) % 2) == 1);
          prevS[ch] = cur;
        end
        pubNow = !runChop || (k >= 2);
      end
      if (pubNow) begin lastPub = t; havePub = 1; end
      expPol  = runChop ? k[0] : 1'b0;
      expFr   = (t == E0) || (runChop && isCap);
      expDrdy = !(havePub && (t - lastPub < HOLD) && !(readAt > lastPub && readAt <= t));
      if (t == E0 && viaEvt)
        chk(drdyN == 1'b1 && chopPol == 1'b0, "R8", "restart state", {62'd0, drdyN, chopPol}, 64'h2);
      chk(chopPol == expPol, "R2", "polarity", 64'(chopPol), 64'(expPol));
      chk(filterRst == expFr, "R3", "filter reset", 64'(filterRst), 64'(expFr));
      chk(drdyN == expDrdy, drdyTag, "data-ready", 64'(drdyN), 64'(expDrdy));
      chk(result == expRes, runChop ? "R6" : "R9", "result", 64'(result), 64'(expRes));
    end
    for (int ch = 0; ch < NCH; ch++) sampleData[ch*SW +: SW] = smp(t, ch);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic startRun(bit chop, int o, int c, bit viaSync, bit viaEvent);
    chopEn = chop; osr = 16'(o); dlyCode = 4'(c);
    if (viaSync) syncN = 1'b0;
    nextE0 = edgeCnt + 1; nextChop = chop; nextOsr = o; nextCode = c;
    nextViaEvt = viaEvent; pending = 1;
    if (viaSync) begin step(3); syncN = 1'b1; end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    chk(1'b0, "R5", "watchdog expired", 64'(edgeCnt), 64'd0);
    summary();
    $finish;
  end

  initial begin
    int o, c;
    void'($urandom(32'd2024));
    step(3);
    // R1 reset state
    chk(drdyN == 1'b1, "R1", "reset drdyN", 64'(drdyN), 64'd1);
    chk(chopPol == 1'b0, "R1", "reset polarity", 64'(chopPol), 64'd0);
    chk(result == '0, "R1", "reset result", 64'(result), 64'd0);
    // R10 gating in chop mode
    chk(phaseCalEn == 1'b0 && dcTestEn == 1'b0, "R10", "cal gating", {62'd0, phaseCalEn, dcTestEn}, 64'd0);
    rst_n = 1'b1;
    nextE0 = edgeCnt + 1; nextChop = 1; nextOsr = 4; nextCode = 0; nextViaEvt = 0; pending = 1;
    step(1);
    chk(drdyN == 1'b1 && chopPol == 1'b0, "R1", "first restart", {62'd0, drdyN, chopPol}, 64'h2);
    step(150);

    // R7 host read releases data-ready early
    drdyTag = "R7";
    while (drdyN !== 1'b0) step(1);
    hostRead = 1'b1; readAt = edgeCnt + 1;
    step(1);
    hostRead = 1'b0;
    step(40);

    // R8 OSR change mid-run restarts without sync
    drdyTag = "R5";
    step(5);
    startRun(1, 5, 1, 0, 1);
    step(180);

    // constrained random chop runs restarted by sync falling edge
    for (int i = 0; i < 4; i++) begin
      o = 1 + int'($urandom % 20);
      c = int'($urandom % 6);
      startRun(1, o, c, 1, 1);
      step(44 + 6 * ((1 << (c + 1)) + 3 * o) - 3);
    end

    // R9 pass-through, entered by mode change
    drdyTag = "R9";
    startRun(0, 10, 2, 0, 1);
    step(5);
    chk(phaseCalEn == 1'b1 && dcTestEn == 1'b1, "R10", "cal follows request", {62'd0, phaseCalEn, dcTestEn}, 64'h3);
    step(80);
    startRun(0, 3, 2, 1, 1);
    step(40);

    // R4 longest delay code, first result only
    drdyTag = "R4";
    startRun(1, 1, 15, 1, 1);
    step(44 + 2 * (65536 + 3) + 20);

    summary();
    $finish;
  end
endmodule